// File: doc/BRIEF.md
# Threshold-Started Serial Audio Delay Line

This block holds back a bit-serial audio stream, and the clock that comes with it, by a programmable whole number of bit-clock periods. On every rising bit-clock edge the serial data bit and the channel-select bit are stored together as one two-bit entry in an internal bit FIFO. The output side stays silent while the FIFO fills. When the number of stored entries reaches the programmed threshold, the output side starts to drain one entry per bit-clock edge. Reads and writes use the same clock, so from then on the fill level stays at the threshold and the stream leaves the block exactly that many bit periods late. One use is to align a high-frequency driver in time with drivers that sit farther from the listener.

The delay is counted in bit periods, so the same threshold gives a different delay in time at each bit-clock rate. With a 4096-entry FIFO and a bit clock near 2.8 MHz, the longest delay is about 1.45 ms. A deeper FIFO, set by a parameter, gives a longer delay. A watchdog runs on a separate free-running clock. If the bit clock stops, the watchdog flushes the FIFO and silences the output at once. When the clock comes back, the block fills again from empty, so no stale audio is played.

Top module: `serial_audio_delay`

## Requirements
- R1: While `rst_n` is low, `out_en`, `ser_out` and `ws_out` are all 0.
- R2: Each stored entry pairs `ser_in` with `ws_in`. Once `out_en` is 1, the `ser_out` and `ws_out` values after bit-clock rising edge k equal the `ser_in` and `ws_in` values sampled at rising edge k-T, where T is the effective threshold.
- R3: After a reset release, the first two rising bit-clock edges store nothing. Storing starts at the third edge. `out_en` rises after the edge that finds T entries stored, which is rising edge T+2 counted from 0 after the release. While `out_en` is 0, `ser_out` and `ws_out` are 0.
- R4: Once `out_en` is 1 it stays 1 for as long as the bit clock keeps running, and the fill level holds at T.
- R5: `thr` is captured on the first storing edge, when the FIFO is empty. Changing `thr` later has no effect on the delay until the next reset or flush.
- R6: A `thr` value of 0 is treated as 1.
- R7: The largest accepted threshold is DEPTH-1 (4095 by default), and it gives a delay of DEPTH-1 bit periods.
- R8: If `wd_clk` sees no rising bit-clock edge for TIMEOUT cycles (256 by default), the FIFO is flushed. `out_en`, `ser_out` and `ws_out` go to 0 at once, with no bit-clock edge needed.
- R9: After a flush, the block refills from empty once the bit clock returns. `out_en` stays 0 for at least T edges after the restart, so only new data ever appears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| wd_clk | input | 1 | Free-running clock for the clock-loss watchdog |
| bclk | input | 1 | Serial bit clock; data is sampled and presented on its rising edge |
| ser_in | input | 1 | Serial audio data bit |
| ws_in | input | 1 | Channel (word) select bit |
| thr | input | $clog2(DEPTH) | Delay threshold in bit periods, captured while the FIFO is empty |
| ser_out | output | 1 | Delayed serial data, 0 while idle |
| ws_out | output | 1 | Delayed channel select, 0 while idle |
| out_en | output | 1 | High while delayed data is being presented |

## Verification
A pseudo-random data stream, paired with a channel select that toggles every 16 bits, is run at a small threshold, at threshold 0 and at the largest threshold. A wrong lag, a swapped channel bit or an off-by-one start edge shows up as a data mismatch. A stream of all ones before a clock stall, followed by random data after the restart, shows whether stale entries survive a flush. A threshold change in the middle of a stream shows whether the captured value really stays locked.

// File: rtl/sad_pkg.sv
package sad_pkg;
   // one FIFO entry: channel select above serial data
   typedef struct packed {
      logic ws;
      logic sd;
   } sad_entry_t;
endpackage

// File: rtl/sad_reset_sync.sv
module sad_reset_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sad_reset_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   // asynchronous assertion, release after STAGES clock edges
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/sad_bit_ram.sv
module sad_bit_ram #(
   parameter int DEPTH = 4096,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic [AW-1:0]        waddr,
   input  sad_pkg::sad_entry_t  wdata,
   input  logic [AW-1:0]        raddr,
   output sad_pkg::sad_entry_t  rdata
);
   sad_pkg::sad_entry_t store [DEPTH];

   // written on every edge; no reset needed since pointers restart on flush
   always_ff @(posedge clk) begin
      store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/sad_watchdog.sv
module sad_watchdog #(
   parameter int TIMEOUT = 256,
   parameter int STAGES  = 2,
   localparam int TW = $clog2(TIMEOUT)
) (
   input  logic wd_clk,
   input  logic rst_n,
   input  logic bclk,
   output logic flush
);
   if (TIMEOUT < 4) begin : g_bad_timeout
      $error("sad_watchdog: TIMEOUT must be at least 4");
   end

   logic [STAGES:0] samp;   // synchroniser stages plus one edge-detect flop
   logic [TW-1:0]   tmr;
   logic            bclk_rise;

   assign bclk_rise = samp[STAGES-1] & ~samp[STAGES];

   always_ff @(posedge wd_clk or negedge rst_n) begin
      if (!rst_n) begin
         samp  <= '0;
         tmr   <= '0;
         flush <= 1'b0;
      end else begin
         samp <= {samp[STAGES-1:0], bclk};
         if (bclk_rise) begin
            tmr   <= '0;
            flush <= 1'b0;   // release only once an edge has been seen again
         end else if (tmr == TW'(TIMEOUT - 1)) begin
            flush <= 1'b1;
         end else begin
            tmr <= tmr + 1'b1;
         end
      end
   end

   AST_FLUSH_STICKY: assert property (@(posedge wd_clk) disable iff (!rst_n)
      (flush && !bclk_rise) |=> flush);   // R8
   AST_FLUSH_RELEASE: assert property (@(posedge wd_clk) disable iff (!rst_n)
      bclk_rise |=> !flush);   // R9
endmodule

// File: rtl/sad_delay_ctrl.sv
module sad_delay_ctrl #(
   parameter int DEPTH = 4096,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                 bclk,
   input  logic                 core_rst_n,
   input  logic [AW-1:0]        thr,
   input  sad_pkg::sad_entry_t  rd_entry,
   output logic [AW-1:0]        wr_ptr,
   output logic [AW-1:0]        rd_ptr,
   output logic                 ser_out,
   output logic                 ws_out,
   output logic                 out_en
);
   logic [AW-1:0] fill;
   logic [AW-1:0] thr_q;
   logic [AW-1:0] thr_eff;
   logic          draining;
   logic          read_now;

   assign thr_eff  = (thr == '0) ? AW'(1) : thr;
   // fill != 0 keeps the reset value of thr_q from starting a read on edge 0
   assign read_now = draining || ((fill == thr_q) && (fill != '0));

   always_ff @(posedge bclk or negedge core_rst_n) begin
      if (!core_rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         fill     <= '0;
         thr_q    <= '0;
         draining <= 1'b0;
         out_en   <= 1'b0;
         ser_out  <= 1'b0;
         ws_out   <= 1'b0;
      end else begin
         wr_ptr <= wr_ptr + 1'b1;
         if (!draining && (fill == '0)) thr_q <= thr_eff;
         if (read_now) begin
            draining <= 1'b1;
            rd_ptr   <= rd_ptr + 1'b1;
            out_en   <= 1'b1;
            ser_out  <= rd_entry.sd;
            ws_out   <= rd_entry.ws;
         end else begin
            fill <= fill + 1'b1;
         end
      end
   end

   AST_LAG_IS_THR: assert property (@(posedge bclk) disable iff (!core_rst_n)
      draining |-> ((wr_ptr - rd_ptr) == thr_q));   // R2
   AST_IDLE_QUIET: assert property (@(posedge bclk) disable iff (!core_rst_n)
      !out_en |-> (!ser_out && !ws_out));   // R3
   AST_FILL_HOLDS: assert property (@(posedge bclk) disable iff (!core_rst_n)
      draining |=> (fill == $past(fill)));   // R4
   AST_THR_LOCKED: assert property (@(posedge bclk) disable iff (!core_rst_n)
      draining |=> $stable(thr_q));   // R5
   AST_THR_NONZERO: assert property (@(posedge bclk) disable iff (!core_rst_n)
      (fill != '0) |-> (thr_q != '0));   // R6
endmodule

// File: rtl/serial_audio_delay.sv
module serial_audio_delay #(
   parameter int DEPTH       = 4096,
   parameter int TIMEOUT     = 256,
   parameter int SYNC_STAGES = 2,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          rst_n,
   input  logic          wd_clk,
   input  logic          bclk,
   input  logic          ser_in,
   input  logic          ws_in,
   input  logic [AW-1:0] thr,
   output logic          ser_out,
   output logic          ws_out,
   output logic          out_en
);
   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("serial_audio_delay: DEPTH must be a power of two, at least 4");
   end

   logic                flush;
   logic                core_arst_n;
   logic                core_rst_n;
   logic [AW-1:0]       wr_ptr;
   logic [AW-1:0]       rd_ptr;
   sad_pkg::sad_entry_t wr_entry;
   sad_pkg::sad_entry_t rd_entry;

   sad_watchdog #(.TIMEOUT(TIMEOUT), .STAGES(SYNC_STAGES)) u_wdog (
      .wd_clk (wd_clk),
      .rst_n  (rst_n),
      .bclk   (bclk),
      .flush  (flush)
   );

   // flush comes from a flop, so it clears the bit-clock domain at once,
   // even when no bit-clock edge arrives
   assign core_arst_n = rst_n & ~flush;

   sad_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
      .clk    (bclk),
      .arst_n (core_arst_n),
      .srst_n (core_rst_n)
   );

   assign wr_entry.ws = ws_in;
   assign wr_entry.sd = ser_in;

   sad_bit_ram #(.DEPTH(DEPTH)) u_ram (
      .clk   (bclk),
      .waddr (wr_ptr),
      .wdata (wr_entry),
      .raddr (rd_ptr),
      .rdata (rd_entry)
   );

   sad_delay_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .bclk       (bclk),
      .core_rst_n (core_rst_n),
      .thr        (thr),
      .rd_entry   (rd_entry),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .ser_out    (ser_out),
      .ws_out     (ws_out),
      .out_en     (out_en)
   );

   AST_RESET_SILENT: assert property (@(posedge wd_clk)
      !rst_n |-> (!out_en && !ser_out && !ws_out));   // R1
endmodule

// File: tb/test_serial_audio_delay.sv
module test_serial_audio_delay;
   localparam int DEPTH   = 4096;
   localparam int TIMEOUT = 256;
   localparam int AW      = $clog2(DEPTH);
   localparam int WD_HALF = 5;    // wd_clk period 10
   localparam int BC_HALF = 40;   // bit clock period 80
   localparam int LIMIT   = 190000;

   logic rst_n = 1'b0, wd_clk = 1'b0, bclk = 1'b0, ser_in = 1'b0, ws_in = 1'b0;
   logic [AW-1:0] thr = '0;
   logic ser_out, ws_out, out_en;
   logic bclk_run = 1'b1;

   int n_checks = 0, n_fail = 0;
   int p = 0;            // index of next rising bit-clock edge
   bit fresh = 1'b0;
   int exp_thr = 1, oe_lo = 0, oe_hi = 0;
   bit hist_d [8192];
   bit hist_w [8192];
   logic [15:0] lfsr = 16'hACE1;
   bit done = 1'b0;

   serial_audio_delay #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) i_serial_audio_delay (
      .rst_n(rst_n), .wd_clk(wd_clk), .bclk(bclk), .ser_in(ser_in), .ws_in(ws_in),
      .thr(thr), .ser_out(ser_out), .ws_out(ws_out), .out_en(out_en)
   );

   always #(WD_HALF) wd_clk = ~wd_clk;
   always begin
      #(BC_HALF);
      if (bclk_run) bclk = ~bclk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, p - 1);
      end
   endtask

   // outputs after rising edge q, sampled on the following falling edge
   task automatic check_prev();
      int q;
      q = p - 1;
      if (q < 0) return;
      if (q < oe_lo) chk(out_en == 1'b0, "R3/R9 out_en early", int'(out_en), 0);
      if (q >= oe_hi) chk(out_en == 1'b1, "R3/R4 out_en", int'(out_en), 1);
      if (out_en) begin
         if (q < exp_thr) chk(1'b0, "R9 output before T edges", q, exp_thr);
         else begin
            chk(ser_out == hist_d[q - exp_thr], "R2 ser_out delay", int'(ser_out), int'(hist_d[q - exp_thr]));
            chk(ws_out == hist_w[q - exp_thr], "R2 ws_out delay", int'(ws_out), int'(hist_w[q - exp_thr]));
         end
      end else begin
         chk(ser_out == 1'b0 && ws_out == 1'b0, "R3 idle outputs", int'({ws_out, ser_out}), 0);
      end
   endtask

   task automatic drive_next(input bit d, input bit w);
      if (!fresh) @(negedge bclk);
      fresh = 1'b0;
      check_prev();
      ser_in = d;
      ws_in  = w;
      hist_d[p] = d;
      hist_w[p] = w;
      p++;
   endtask

   function automatic bit prbs();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic do_reset(input int thr_val, input int t_eff);
      @(negedge bclk);
      rst_n = 1'b0;
      repeat (3) @(negedge bclk);
      chk(out_en == 1'b0 && ser_out == 1'b0 && ws_out == 1'b0, "R1 reset outputs",
          int'({out_en, ws_out, ser_out}), 0);
      thr = AW'(thr_val);
      exp_thr = t_eff;
      oe_lo = t_eff + 2;
      oe_hi = t_eff + 2;
      @(negedge bclk);
      rst_n = 1'b1;
      p = 0;
      fresh = 1'b1;
   endtask

   task automatic run_prbs(input int n);
      for (int i = 0; i < n; i++) drive_next(prbs(), ((p / 16) % 2) == 1);
   endtask

   task automatic test_basic_delay();   // R2 R3 R4
      do_reset(9, 9);
      run_prbs(200);
   endtask

   task automatic test_zero_thr();      // R6
      do_reset(0, 1);
      run_prbs(80);
   endtask

   task automatic test_thr_locked();    // R5
      do_reset(8, 8);
      run_prbs(40);
      thr = AW'(20);
      run_prbs(100);
   endtask

   task automatic test_max_thr();       // R7
      do_reset(DEPTH - 1, DEPTH - 1);
      run_prbs(DEPTH + 100);
   endtask

   task automatic test_stall();         // R8 R9
      do_reset(12, 12);
      for (int i = 0; i < 60; i++) drive_next(1'b1, 1'b1);
      @(negedge bclk);
      check_prev();
      bclk_run = 1'b0;
      repeat (TIMEOUT + 44) @(posedge wd_clk);
      #1;
      chk(out_en == 1'b0, "R8 out_en after stall", int'(out_en), 0);
      chk(ser_out == 1'b0 && ws_out == 1'b0, "R8 data after stall", int'({ws_out, ser_out}), 0);
      p = 0;
      fresh = 1'b1;
      oe_lo = 12 + 2;
      oe_hi = 12 + 4;
      bclk_run = 1'b1;
      run_prbs(120);
   endtask

   initial begin
      test_basic_delay();
      test_zero_thr();
      test_thr_locked();
      test_max_thr();
      test_stall();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge wd_clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule